// File: doc/BRIEF.md
# HDLC Receive Frame Check Sequence Checker

This block sits behind the flag detector and zero-bit remover of an HDLC receiver. It accepts the de-stuffed frame one byte per cycle, with a start marker on the first byte and an end marker on the last. While the frame streams through, it runs a byte-wide CRC-16 or CRC-32 over every byte, checksum included. At the end it compares the register against the fixed good-frame residue.

Bytes leave the block toward the receive FIFO with one cycle of latency. In removal mode the last 2 or 4 bytes of the frame (the checksum) are held back in a short delay line and dropped. In forwarding mode they go out as ordinary data. A disable control switches CRC checking off entirely, so every byte is forwarded. One cycle after the last input byte, a three-bit end-of-frame status appears, in the same cycle as the last forwarded byte, if there is one.

Top module: `hdlc_rx_fcs_check`

## Requirements
- R1: With `cfg_no_crc`=0 and `cfg_crc32`=0, status bit 0 (crc_ok) is 1 exactly when the CRC over all bytes of the frame leaves the residue 0xF0B8. The CRC uses polynomial x^16+x^12+x^5+1, bits are taken LSB first, and the register is preset to 0xFFFF.
- R2: With `cfg_no_crc`=0 and `cfg_crc32`=1, crc_ok is 1 exactly when the CRC over all bytes leaves the residue 0xDEBB20E3. The CRC uses polynomial 0x04C11DB7, bits are taken LSB first, and the register is preset to 0xFFFFFFFF.
- R3: With `cfg_no_crc`=0 and `cfg_keep_fcs`=0, the last 2 (CRC-16) or 4 (CRC-32) bytes of a frame are never output. All earlier bytes are output in order. The first byte of a frame is never output in the cycle after it is taken in.
- R4: With `cfg_no_crc`=0 and `cfg_keep_fcs`=1, every byte of the frame, checksum included, is output in order, one cycle after it is taken in.
- R5: With `cfg_no_crc`=1, `cfg_keep_fcs` has no effect. Every byte is output one cycle after it is taken in, crc_ok is 0, and frame validity depends on length alone.
- R6: Status bit 2 (short) is 1 when the frame holds fewer bytes than the minimum. The minimum is the checksum length plus 1 when CRC is enabled, and 1 when it is disabled. A short frame always has status bit 1 (valid) at 0.
- R7: Status bit 1 (valid) is 1 when the frame is not short and, with CRC enabled, crc_ok is 1.
- R8: `out_eof` pulses for one cycle, one cycle after the byte carrying `in_eof`. It carries `out_status` as {short, valid, crc_ok}. If the frame forwards any byte, the last forwarded byte is presented in that same cycle.
- R9: A byte with `in_valid`=1 that arrives outside a frame (no `in_sof` since the last `in_eof`) is ignored. A new `in_sof` restarts the CRC, the length count and the delay line, even when the previous frame had no end marker.
- R10: After reset, `out_valid`, `out_eof`, `out_data` and `out_status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_crc32 | input | 1 | 1 selects CRC-32 (4 checksum bytes), 0 selects CRC-16 (2 bytes) |
| cfg_no_crc | input | 1 | 1 disables CRC checking |
| cfg_keep_fcs | input | 1 | 1 forwards the checksum bytes, 0 removes them |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| out_eof | output | 1 | End-of-frame status strobe |
| out_status | output | 3 | {short, valid, crc_ok}, meaningful with out_eof |

## Verification
The bench sweeps all eight combinations of width, forwarding and disable. Each combination gets payloads of 0 to 6 bytes, with a correct checksum and with one flipped bit. Correct frames separate the two residues and polynomials. Flipped frames show whether crc_ok and valid really depend on the data. Payloads of zero bytes fall below the minimum length yet still carry a matching checksum, which shows that the short rule overrides a good CRC. Idle gaps inside a frame, stray bytes before a start marker, and an unterminated frame cut off by a new start marker separate correct frame tracking from byte counting that ignores the markers.

// File: rtl/hdlc_fcs_pkg.sv
// Shared types and CRC step functions for the HDLC receive checksum checker.
// Assumes byte-wide data, bits taken least significant first (reflected CRC).
package hdlc_fcs_pkg;

    localparam int unsigned BYTE_W = 8;

    // End-of-frame status, bit 2 short, bit 1 valid, bit 0 crc_ok.
    typedef struct packed {
        logic short_frame;
        logic frame_ok;
        logic crc_ok;
    } fcs_status_t;

    localparam logic [15:0] CRC16_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC16_RESIDUE = 16'hF0B8;
    localparam logic [15:0] CRC16_POLY_R  = 16'h8408;   // reflected 0x1021
    localparam logic [31:0] CRC32_PRESET  = 32'hFFFFFFFF;
    localparam logic [31:0] CRC32_RESIDUE = 32'hDEBB20E3;
    localparam logic [31:0] CRC32_POLY_R  = 32'hEDB88320; // reflected 0x04C11DB7

    // Advance a reflected CRC-16 by one byte.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC16_POLY_R;
        end
        return r;
    endfunction

    // Advance a reflected CRC-32 by one byte.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC32_POLY_R;
        end
        return r;
    endfunction

endpackage

// File: rtl/fcs_crc_engine.sv
// Byte-wide CRC register for CRC-16 or CRC-32, chosen per frame by 'wide'.
// The match output compares the post-byte value against the good residue,
// so it is meaningful in the cycle of the last byte of a frame.
// Assumes 'restart' is asserted with the first byte of each frame.
module fcs_crc_engine
    import hdlc_fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              restart,
    input  logic              wide,
    input  logic [BYTE_W-1:0] din,
    output logic              match
);
    logic [31:0] crc_q;
    logic [31:0] base;
    logic [31:0] crc_nxt;

    // Pick the seed or running value, then advance by one byte.
    always_comb begin
        if (restart) base = wide ? CRC32_PRESET : {16'h0000, CRC16_PRESET};
        else         base = crc_q;
        if (wide) crc_nxt = crc32_step(base, din);
        else      crc_nxt = {16'h0000, crc16_step(base[15:0], din)};
        match = wide ? (crc_nxt == CRC32_RESIDUE) : (crc_nxt[15:0] == CRC16_RESIDUE);
    end

    // Hold the running CRC between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= '0;
        else if (step) crc_q <= crc_nxt;
    end
endmodule

// File: rtl/fcs_len_count.sv
// Saturating byte counter for the frame in progress. len_now includes the
// byte presented this cycle. Assumes 'restart' marks the first byte.
module fcs_len_count #(
    parameter int unsigned LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    output logic [LEN_W-1:0] len_now
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;
    logic [LEN_W-1:0] len_q;

    // Count including the current byte, saturating at the maximum.
    always_comb begin
        if (restart)              len_now = LEN_W'(1);
        else if (len_q == LEN_MAX) len_now = LEN_MAX;
        else                      len_now = len_q + LEN_W'(1);
    end

    // Register the count on every accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    len_q <= '0;
        else if (step) len_q <= len_now;
    end
endmodule

// File: rtl/fcs_hold_line.sv
// Delay line that holds back the newest 'depth' bytes of a frame. When a
// byte is pushed while 'depth' bytes are already held, the oldest held byte
// is released in the same cycle. A flush empties the line after the push.
// Assumes depth is between 1 and DEPTH and is stable within a frame.
module fcs_hold_line #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         restart,
    input  logic                         flush,
    input  logic [$clog2(DEPTH+1)-1:0]   depth,
    input  logic [DW-1:0]                din,
    output logic                         rel_valid,
    output logic [DW-1:0]                rel_data
);
    localparam int unsigned FILL_W = $clog2(DEPTH + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

    logic [DW-1:0]     stage_q [DEPTH];
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] fill_nxt;

    // Release the oldest held byte when the line is full to 'depth'.
    always_comb begin
        rel_valid = push && !restart && (fill_q >= depth);
        rel_data  = stage_q[depth - FILL_W'(1)];
    end

    // Next fill level: empty after a flush, one after a restart, else count up.
    always_comb begin
        if (!push)                 fill_nxt = fill_q;
        else if (flush)            fill_nxt = '0;
        else if (restart)          fill_nxt = FILL_W'(1);
        else if (fill_q == FILL_MAX) fill_nxt = FILL_MAX;
        else                       fill_nxt = fill_q + FILL_W'(1);
    end

    // Track how many valid bytes the line holds.
    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_nxt;
    end

    // Newest byte enters stage 0.
    always_ff @(posedge clk) begin
        if (!rst_n)    stage_q[0] <= '0;
        else if (push) stage_q[0] <= din;
    end

    // Remaining stages shift one step older on each push.
    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)    stage_q[i] <= '0;
            else if (push) stage_q[i] <= stage_q[i-1];
        end
    end

    // R3: the line never claims more bytes than it has stages.
    a_r3_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_MAX);

    // R3: an end-of-frame push leaves the line empty for the next frame.
    a_r3_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (push && flush) |=> (fill_q == '0));
endmodule

// File: rtl/hdlc_rx_fcs_check.sv
// HDLC receive checksum checker. Runs CRC-16 or CRC-32 over each framed
// byte stream, forwards or strips the checksum bytes, and emits a status
// word one cycle after the last input byte. Assumes the configuration
// inputs are stable for the duration of a frame.
module hdlc_rx_fcs_check
    import hdlc_fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_crc32,
    input  logic       cfg_no_crc,
    input  logic       cfg_keep_fcs,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_eof,
    output logic [2:0] out_status
);
    localparam int unsigned MAX_FCS = 4;
    localparam int unsigned FILL_W  = $clog2(MAX_FCS + 1);
    localparam int unsigned LEN_W   = $clog2(MAX_FCS + 2);

    logic              in_frame_q;
    logic              acc;
    logic              strip_mode;
    logic [FILL_W-1:0] fcs_len;
    logic [LEN_W-1:0]  min_len;
    logic [LEN_W-1:0]  len_now;
    logic              crc_match;
    logic              rel_valid;
    logic [7:0]        rel_data;
    logic              fwd_valid;
    logic [7:0]        fwd_data;
    fcs_status_t       stat_now;

    // Accept a byte if it opens a frame or falls inside one.
    always_comb begin
        acc        = in_valid && (in_sof || in_frame_q);
        strip_mode = !cfg_no_crc && !cfg_keep_fcs;
        fcs_len    = cfg_crc32 ? FILL_W'(4) : FILL_W'(2);
        min_len    = cfg_no_crc ? LEN_W'(1) : LEN_W'(fcs_len) + LEN_W'(1);
    end

    // Track whether a frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n)               in_frame_q <= 1'b0;
        else if (acc && in_eof)   in_frame_q <= 1'b0;
        else if (acc)             in_frame_q <= 1'b1;
    end

    fcs_crc_engine u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (acc),
        .restart (in_sof),
        .wide    (cfg_crc32),
        .din     (in_data),
        .match   (crc_match)
    );

    fcs_len_count #(.LEN_W(LEN_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (acc),
        .restart (in_sof),
        .len_now (len_now)
    );

    fcs_hold_line #(.DEPTH(MAX_FCS), .DW(BYTE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (acc),
        .restart   (in_sof),
        .flush     (in_eof),
        .depth     (fcs_len),
        .din       (in_data),
        .rel_valid (rel_valid),
        .rel_data  (rel_data)
    );

    // Choose the byte to forward and form the end-of-frame status.
    always_comb begin
        fwd_valid            = strip_mode ? rel_valid : acc;
        fwd_data             = strip_mode ? rel_data  : in_data;
        stat_now.crc_ok      = !cfg_no_crc && crc_match;
        stat_now.short_frame = len_now < min_len;
        stat_now.frame_ok    = !stat_now.short_frame && (cfg_no_crc || crc_match);
    end

    // Register the output byte and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_eof    <= 1'b0;
            out_status <= '0;
        end else begin
            out_valid  <= fwd_valid;
            out_data   <= fwd_valid ? fwd_data : 8'h00;
            out_eof    <= acc && in_eof;
            out_status <= (acc && in_eof) ? stat_now : 3'b000;
        end
    end

    // R4, R5: in pass-through modes each accepted byte appears one cycle later.
    a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !strip_mode) |=> (out_valid && out_data == $past(in_data)));

    // R3: the first byte of a frame is held back in removal mode.
    a_r3_first_held: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_sof && strip_mode) |=> !out_valid);

    // R8: status strobe follows the end-marked byte by one cycle.
    a_r8_eof_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_eof) |=> out_eof);

    // R9: a stray byte outside a frame produces no output.
    a_r9_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof && !in_frame_q) |=> (!out_valid && !out_eof));

    // R6: a short frame is never reported valid.
    a_r6_short_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && out_status[2]) |-> !out_status[1]);
endmodule

// File: tb/hdlc_rx_fcs_check_test.sv
module hdlc_rx_fcs_check_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_crc32 = 1'b0, cfg_no_crc = 1'b0, cfg_keep_fcs = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid, out_eof;
    logic [7:0] out_data;
    logic [2:0] out_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] frm [32];
    logic [7:0] got [32];
    int         got_n;
    int         stat_seen;
    logic [2:0] stat_got;
    logic       eof_byte;

    always #5 clk = ~clk;

    hdlc_rx_fcs_check uut (
        .clk(clk), .rst_n(rst_n), .cfg_crc32(cfg_crc32), .cfg_no_crc(cfg_no_crc),
        .cfg_keep_fcs(cfg_keep_fcs), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid), .out_data(out_data),
        .out_eof(out_eof), .out_status(out_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bit-serial reflected CRC over frm[0..n-1].
    function automatic logic [31:0] ref_crc(input bit wide, input int n);
        logic [31:0] c;
        logic [31:0] p;
        c = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
        p = wide ? 32'hEDB88320 : 32'h00008408;
        for (int k = 0; k < n; k++)
            for (int b = 0; b < 8; b++)
                c = (c >> 1) ^ (p & {32{c[0] ^ frm[k][b]}});
        return wide ? c : {16'h0, c[15:0]};
    endfunction

    task automatic clear_rec();
        got_n = 0; stat_seen = 0; stat_got = 3'b000; eof_byte = 1'b0;
    endtask

    // Advance one cycle and record what the outputs show.
    task automatic tick();
        @(negedge clk);
        if (out_valid) begin
            if (got_n < 32) got[got_n] = out_data;
            got_n++;
        end
        if (out_eof) begin
            stat_seen++;
            stat_got = out_status;
            eof_byte = out_valid;
        end
    endtask

    task automatic drive(input logic [7:0] d, input bit s, input bit e);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
        tick();
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    endtask

    task automatic send_frame(input int pay, input bit corrupt, input bit gaps, input bit prefix);
        int          n;
        int          dl;
        int          fwd;
        int          bad;
        logic [31:0] c;
        logic [31:0] res;
        bit          crc_ok_e, short_e, valid_e;
        logic [2:0]  st_e;
        string       tag;
        dl = cfg_crc32 ? 4 : 2;
        for (int i = 0; i < pay; i++) frm[i] = 8'((pay * 37) + (i * 11) + 8'h5A);
        n = pay;
        if (!cfg_no_crc) begin
            c = ~ref_crc(cfg_crc32, pay);
            for (int i = 0; i < dl; i++) frm[n + i] = c[8*i +: 8];
            n = n + dl;
        end
        if (corrupt) frm[0] = frm[0] ^ 8'h01;
        res = ref_crc(cfg_crc32, n);
        crc_ok_e = !cfg_no_crc && (cfg_crc32 ? (res == 32'hDEBB20E3) : (res[15:0] == 16'hF0B8));
        short_e  = cfg_no_crc ? (n < 1) : (n < dl + 1);
        valid_e  = !short_e && (cfg_no_crc || crc_ok_e);
        st_e     = {short_e, valid_e, crc_ok_e};
        fwd      = (!cfg_no_crc && !cfg_keep_fcs) ? ((n > dl) ? n - dl : 0) : n;
        if (prefix) begin
            // R9: unterminated frame, then a new start marker restarts everything
            drive(8'hC3, 1'b1, 1'b0);
            drive(8'h3C, 1'b0, 1'b0);
            drive(8'h99, 1'b0, 1'b0);
        end
        clear_rec();
        for (int i = 0; i < n; i++) begin
            drive(frm[i], i == 0, i == n - 1);
            if (gaps && i != n - 1) tick();
        end
        tick();
        tag = cfg_no_crc ? "R5" : (cfg_keep_fcs ? "R4" : "R3");
        if (prefix) tag = {tag, "/R9"};
        check(got_n == fwd, tag, got_n, fwd);
        bad = 0;
        for (int i = 0; i < fwd && i < got_n; i++) if (got[i] !== frm[i]) bad++;
        check(bad == 0, {tag, " byte order"}, bad, 0);
        check(stat_seen == 1, "R8 one status strobe", stat_seen, 1);
        check(eof_byte == (fwd > 0), "R8 last byte with status", eof_byte, fwd > 0);
        tag = cfg_no_crc ? "R5/R6/R7" : (cfg_crc32 ? "R2/R6/R7" : "R1/R6/R7");
        check(stat_got == st_e, tag, stat_got, st_e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state of all outputs
        check({out_valid, out_eof, out_data, out_status} == '0, "R10 reset outputs",
              {out_valid, out_eof, out_data, out_status}, 0);

        // R9: stray bytes before any start marker are ignored
        clear_rec();
        drive(8'h11, 1'b0, 1'b0);
        drive(8'h22, 1'b0, 1'b1);
        tick();
        check(got_n == 0 && stat_seen == 0, "R9 stray bytes", got_n + stat_seen, 0);

        for (int mode = 0; mode < 8; mode++) begin
            cfg_crc32    = mode[0];
            cfg_keep_fcs = mode[1];
            cfg_no_crc   = mode[2];
            for (int p = 0; p < 7; p++) begin
                for (int cr = 0; cr < 2; cr++) begin
                    if (cfg_no_crc && (p == 0 || cr == 1)) continue;
                    send_frame(p, cr[0], p[0], p == 3);
                end
            end
        end

        // R9: stray byte right after a frame end is ignored
        cfg_crc32 = 1'b0; cfg_keep_fcs = 1'b1; cfg_no_crc = 1'b0;
        clear_rec();
        drive(8'h77, 1'b0, 1'b0);
        tick();
        check(got_n == 0 && stat_seen == 0, "R9 stray after frame", got_n + stat_seen, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule